// File: doc/BRIEF.md
# Pipelined Converter Code Aligner and Merger

This block is the digital back end of a four-stage pipelined analog-to-digital converter. On every clock it receives one raw code from each stage. Stages one to three each give a 3-bit code. The final stage gives a 4-bit code. A stage always works on an older sample than the stage ahead of it. The codes that belong to one sample therefore arrive one cycle apart. The block holds each early code in a delay line of its own depth, so that the four codes of one sample meet in the same cycle.

The residue is amplified by four between stages. Each stage's code therefore carries weight four times that of the next stage, and neighbouring codes share one bit position. The aligned codes are merged with a chain of carry-propagating adders, built from full and half adder cells, into one 10-bit binary word. The adder result is registered once, and a valid flag travels with it.

A sample is announced by `in_vld` in the cycle in which its stage-one code is on `code_s1`. Its stage-two, stage-three and final codes follow on the three next cycles.

Top module: `pam_align_merge`

## Requirements
- R1: While `rst_n` is low at a rising edge, all delay stages and the output register are cleared. After that edge `word_out` reads 0 and `word_vld` reads 0.
- R2: A sample whose stage-one code is presented in cycle t is merged with the stage-two code presented in cycle t+1, the stage-three code presented in cycle t+2 and the final-stage code presented in cycle t+3.
- R3: The merged value is `code_s1*64 + code_s2*16 + code_s3*4 + code_s4`, with every code unsigned. It appears on the 10-bit `word_out`, whose bit 0 is the least significant bit.
- R4: `word_vld` is high in cycle t+4 exactly when `in_vld` was high in cycle t. It is low in every other cycle.
- R5: In a cycle where `word_vld` is low, `word_out` keeps the last merged value. If no sample has completed since reset, it keeps 0. Codes presented without a valid strobe do not change it.
- R6: Samples may start on every clock cycle. Back-to-back samples each produce their own correct word on consecutive cycles.
- R7: Carries propagate across the overlapping bit positions. All-ones codes (7, 7, 7, 15) give 603, the largest value, without overflow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_vld | input | 1 | Marks the cycle in which a new sample's stage-one code is present |
| code_s1 | input | 3 | Stage-one raw code (newest sample) |
| code_s2 | input | 3 | Stage-two raw code (sample one cycle older) |
| code_s3 | input | 3 | Stage-three raw code (sample two cycles older) |
| code_s4 | input | 4 | Final-stage raw code (sample three cycles older) |
| word_out | output | 10 | Merged binary word |
| word_vld | output | 1 | High for one cycle per merged sample |

## Verification
The assertions take for granted that the stage codes follow the pipeline skew. In each cycle, `code_s2`, `code_s3` and `code_s4` belong to the samples started one, two and three cycles earlier. They also take for granted that `in_vld` is a known level whenever reset is released. The stimulus guarantees both. It builds a list of samples and drives each one's four codes at their skewed offsets. Stage inputs with no sample behind them are driven to zero. The strobe stays low during reset and is driven on every cycle after it.

// File: rtl/pam_pkg.sv
// Package: shared sizing constants and a width helper for the code aligner.
// Assumes every intermediate stage emits codes of the same width.
package pam_pkg;

    localparam int STAGES_DEF = 4;
    localparam int CODE_W_DEF = 3;
    localparam int LAST_W_DEF = 4;
    localparam int SHIFT_DEF  = 2;

    // Width needed to hold the largest merged value without overflow.
    function automatic int merged_width(int stages, int code_w, int last_w, int shift);
        longint maxv;
        maxv = (longint'(1) << last_w) - 1;
        for (int i = 1; i < stages; i++) begin
            maxv += ((longint'(1) << code_w) - 1) << (shift * i);
        end
        return $clog2(maxv + 1);
    endfunction

endpackage

// File: rtl/pam_code_delay.sv
// Module: fixed-depth serial shift delay for one stage code.
// DEPTH = 0 gives a plain wire. Otherwise q equals d from DEPTH cycles earlier.
// Assumes a synchronous active-low reset that clears every tap.
module pam_code_delay #(
    parameter int W     = 4,
    parameter int DEPTH = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    generate
        if (DEPTH == 0) begin : g_wire
            assign q = d;
        end else begin : g_shift
            logic [W-1:0] taps [DEPTH];

            // Shift the code one tap per clock; clear all taps on reset.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    for (int k = 0; k < DEPTH; k++) taps[k] <= '0;
                end else begin
                    taps[0] <= d;
                    for (int k = 1; k < DEPTH; k++) taps[k] <= taps[k-1];
                end
            end

            assign q = taps[DEPTH-1];
        end
    endgenerate

endmodule

// File: rtl/pam_full_add.sv
// Module: one-bit full adder cell.
// The sum is the XOR of both operands and the carry-in.
module pam_full_add (
    input  logic a,
    input  logic b,
    input  logic ci,
    output logic s,
    output logic co
);

    // Sum and carry of three one-bit inputs.
    always_comb begin
        s  = a ^ b ^ ci;
        co = (a & b) | (ci & (a ^ b));
    end

endmodule

// File: rtl/pam_ripple_add.sv
// Module: W-bit ripple adder built from full adder cells.
// Assumes the caller knows the sum fits in W bits, so the top bit keeps
// only its sum and no carry-out is produced. Needs W >= 2.
module pam_ripple_add #(
    parameter int W = 10
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] s
);

    logic [W-1:0] c;

    assign c[0] = 1'b0;

    generate
        for (genvar i = 0; i < W; i++) begin : g_bit
            if (i < W - 1) begin : g_cell
                pam_full_add u_fa (
                    .a  (a[i]),
                    .b  (b[i]),
                    .ci (c[i]),
                    .s  (s[i]),
                    .co (c[i+1])
                );
            end else begin : g_top
                assign s[i] = a[i] ^ b[i] ^ c[i];
            end
        end
    endgenerate

endmodule

// File: rtl/pam_align_merge.sv
// Module: top of the pipelined converter back end.
// Delays each stage code so one sample's codes meet, merges them by
// shift-and-add (Horner form, SHIFT bits per stage) and registers the word.
// Assumes stage k presents the code of the sample started k-1 cycles before,
// and that in_vld marks the cycle of a sample's stage-one code.
module pam_align_merge
    import pam_pkg::*;
#(
    parameter int CODE_W = CODE_W_DEF,
    parameter int LAST_W = LAST_W_DEF,
    parameter int SHIFT  = SHIFT_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_vld,
    input  logic [CODE_W-1:0] code_s1,
    input  logic [CODE_W-1:0] code_s2,
    input  logic [CODE_W-1:0] code_s3,
    input  logic [LAST_W-1:0] code_s4,
    output logic [merged_width(STAGES_DEF, CODE_W, LAST_W, SHIFT)-1:0] word_out,
    output logic              word_vld
);

    localparam int STAGES = STAGES_DEF;
    localparam int OUT_W  = merged_width(STAGES, CODE_W, LAST_W, SHIFT);
    localparam int PAD_W  = LAST_W - CODE_W;

    logic [STAGES-1:0][LAST_W-1:0] raw_code;
    logic [STAGES-1:0][LAST_W-1:0] al_code;
    logic [OUT_W-1:0]              acc [STAGES];
    logic                          al_vld;
    logic [OUT_W-1:0]              word_q;
    logic                          vld_q;

    // Gather the stage codes into one array of uniform width.
    assign raw_code[0] = {{PAD_W{1'b0}}, code_s1};
    assign raw_code[1] = {{PAD_W{1'b0}}, code_s2};
    assign raw_code[2] = {{PAD_W{1'b0}}, code_s3};
    assign raw_code[3] = code_s4;

    // Delay each stage by the number of stages still ahead of it.
    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_align
            pam_code_delay #(
                .W     (LAST_W),
                .DEPTH (STAGES - 1 - i)
            ) u_dly (
                .clk   (clk),
                .rst_n (rst_n),
                .d     (raw_code[i]),
                .q     (al_code[i])
            );
        end
    endgenerate

    // The strobe travels with the stage-one code.
    pam_code_delay #(
        .W     (1),
        .DEPTH (STAGES - 1)
    ) u_vld_dly (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (in_vld),
        .q     (al_vld)
    );

    // Horner merge: acc[i] = acc[i-1]*2^SHIFT + aligned code i.
    assign acc[0] = {{(OUT_W-LAST_W){1'b0}}, al_code[0]};

    generate
        for (genvar i = 1; i < STAGES; i++) begin : g_merge
            pam_ripple_add #(
                .W (OUT_W)
            ) u_add (
                .a (acc[i-1] << SHIFT),
                .b ({{(OUT_W-LAST_W){1'b0}}, al_code[i]}),
                .s (acc[i])
            );
        end
    endgenerate

    // Output register: capture the merged word only for a valid sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
            vld_q  <= 1'b0;
        end else begin
            vld_q <= al_vld;
            if (al_vld) word_q <= acc[STAGES-1];
        end
    end

    assign word_out = word_q;
    assign word_vld = vld_q;

endmodule

// File: rtl/pam_align_merge_chk.sv
// Checker: protocol and arithmetic properties of pam_align_merge, bound below.
// Assumes a synchronous active-low reset asserted from time zero.
module pam_align_merge_chk #(
    parameter int STAGES = 4,
    parameter int LAST_W = 4,
    parameter int SHIFT  = 2,
    parameter int OUT_W  = 10,
    parameter int MAXV   = 603
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          in_vld,
    input logic                          al_vld,
    input logic [STAGES-1:0][LAST_W-1:0] al_code,
    input logic [OUT_W-1:0]              word_out,
    input logic                          word_vld
);

    logic [STAGES-1:0] vld_hist;
    int                ref_sum;
    logic              rst_prev;

    // Independent record of the strobe over the last STAGES cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) vld_hist <= '0;
        else        vld_hist <= {vld_hist[STAGES-2:0], in_vld};
    end

    // Reference merge by multiplication over the aligned codes.
    always_comb begin
        ref_sum = 0;
        for (int i = 0; i < STAGES; i++) begin
            ref_sum += int'(al_code[i]) * (1 << (SHIFT * (STAGES - 1 - i)));
        end
    end

    // Remember the reset level of the previous edge.
    always_ff @(posedge clk) rst_prev <= rst_n;

    // R1: after a reset edge the outputs read zero.
    always @(negedge clk) begin
        if (rst_prev === 1'b0) begin
            assert_reset_clear_R1: assert (word_out == '0 && word_vld == 1'b0);
        end
    end

    // R4: the output flag equals the strobe from STAGES cycles earlier.
    assert_vld_latency_R4: assert property (@(posedge clk) disable iff (!rst_n)
        word_vld == vld_hist[STAGES-1]);

    // R3: a valid aligned set produces its weighted sum on the next cycle.
    assert_sum_R3: assert property (@(posedge clk) disable iff (!rst_n)
        al_vld |=> (int'(word_out) == $past(ref_sum)));

    // R3 / R7: the word never exceeds the largest legal value.
    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        int'(word_out) <= MAXV);

    // R5: without a valid aligned set the word holds.
    assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !al_vld |=> $stable(word_out));

endmodule

bind pam_align_merge pam_align_merge_chk #(
    .STAGES (STAGES),
    .LAST_W (LAST_W),
    .SHIFT  (SHIFT),
    .OUT_W  (OUT_W),
    .MAXV   ((1 << OUT_W) - 1 < 603 ? (1 << OUT_W) - 1 : 603)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_vld   (in_vld),
    .al_vld   (al_vld),
    .al_code  (al_code),
    .word_out (word_out),
    .word_vld (word_vld)
);

// File: tb/tb_pam_align_merge.sv
// Bench: skewed sample stream, directed corners plus seeded random codes,
// compared against a shift-and-add model.
module tb_pam_align_merge;

    localparam int CLK_PERIOD = 10;
    localparam int N          = 200;
    localparam int LAT        = 4;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       in_vld;
    logic [2:0] code_s1, code_s2, code_s3;
    logic [3:0] code_s4;
    logic [9:0] word_out;
    logic       word_vld;

    int    s1 [N];
    int    s2 [N];
    int    s3 [N];
    int    s4 [N];
    bit    sv [N];
    string stag [N];

    int ntest = 0;
    int nfail = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pam_align_merge dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_vld   (in_vld),
        .code_s1  (code_s1),
        .code_s2  (code_s2),
        .code_s3  (code_s3),
        .code_s4  (code_s4),
        .word_out (word_out),
        .word_vld (word_vld)
    );

    // Expected merge from the stated weights (R3).
    function automatic int ref_word(int a, int b, int c, int d);
        return a * 64 + b * 16 + c * 4 + d;
    endfunction

    task automatic check(string tag, int act, int exp);
        ntest++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic set_smp(int k, bit v, int a, int b, int c, int d, string tag);
        sv[k] = v; s1[k] = a; s2[k] = b; s3[k] = c; s4[k] = d; stag[k] = tag;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            nfail++;
            ntest++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  [TB] %0d tests run, %0d failed", ntest, nfail);
            $finish;
        end
    end

    initial begin
        int last;
        void'($urandom(32'h5A17));

        // Directed corners first, then random, then a back-to-back block.
        set_smp(0, 1, 7, 7, 7, 15, "R7");
        set_smp(1, 1, 0, 0, 0, 0,  "R3");
        set_smp(2, 1, 1, 0, 0, 0,  "R2");
        set_smp(3, 1, 0, 0, 0, 1,  "R2");
        set_smp(4, 0, 5, 5, 5, 9,  "R5");
        set_smp(5, 1, 0, 3, 7, 15, "R7");
        set_smp(6, 1, 0, 0, 1, 0,  "R2");
        for (int k = 7; k < 150; k++) begin
            set_smp(k, ($urandom % 4) != 0, $urandom % 8, $urandom % 8,
                    $urandom % 8, $urandom % 16, "R3");
        end
        for (int k = 150; k < N; k++) begin
            set_smp(k, 1, $urandom % 8, $urandom % 8, $urandom % 8,
                    $urandom % 16, "R6");
        end

        rst_n = 1'b0; in_vld = 1'b0;
        code_s1 = '0; code_s2 = '0; code_s3 = '0; code_s4 = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 word after reset", int'(word_out), 0);
        check("R1 vld after reset",  int'(word_vld), 0);

        rst_n = 1'b1;
        last  = 0;
        for (int t = 0; t < N + LAT + 1; t++) begin
            int j;
            j = t - LAT;
            // Outputs for the sample started LAT cycles ago.
            if (j >= 0 && j < N && sv[j]) begin
                last = ref_word(s1[j], s2[j], s3[j], s4[j]);
                check({stag[j], " word"}, int'(word_out), last);
                check("R4 vld high", int'(word_vld), 1);
            end else begin
                check("R4 vld low", int'(word_vld), 0);
                check("R5 hold", int'(word_out), last);
            end
            // Skewed stage codes for this cycle.
            in_vld  = (t < N) ? sv[t] : 1'b0;
            code_s1 = (t < N) ? 3'(s1[t]) : 3'd0;
            code_s2 = (t - 1 >= 0 && t - 1 < N) ? 3'(s2[t-1]) : 3'd0;
            code_s3 = (t - 2 >= 0 && t - 2 < N) ? 3'(s3[t-2]) : 3'd0;
            code_s4 = (t - 3 >= 0 && t - 3 < N) ? 4'(s4[t-3]) : 4'd0;
            @(negedge clk);
        end

        // Reset in mid-flight with a sample entering.
        in_vld = 1'b1; code_s1 = 3'd7;
        @(negedge clk);
        in_vld = 1'b0; rst_n = 1'b0;
        @(negedge clk);
        check("R1 word after mid reset", int'(word_out), 0);
        check("R1 vld after mid reset",  int'(word_vld), 0);
        rst_n = 1'b1;
        repeat (LAT) @(negedge clk);
        check("R1 flushed sample vld", int'(word_vld), 0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", ntest, nfail);
        $finish;
    end

endmodule